// File: doc/BRIEF.md
# Stereo Zero-Data Detector

This block watches a stereo audio stream one frame at a time. A strobe marks each word-clock period. When the strobe is high, the block looks at one left sample and one right sample. It raises a single zero-detect flag once both channels have carried nothing but all-zero words for a long unbroken run of frames. Downstream logic can use the flag to mute or power down an output path while the source is silent.

The flag drops at the first frame in which either channel carries a nonzero word. The run count restarts at that frame, so a new assertion needs a full run again. Cycles without a strobe are not frames: they neither extend the run nor break it, whatever values sit on the sample inputs.

Top module: `stereo_zero_detect`

## Requirements
- R1: A synchronous active-high reset clears the flag and the run count. After reset is released, a full run of zero frames is needed before the flag rises.
- R2: The flag goes high on the clock edge that registers the strobe of the RUN_FRAMES-th consecutive frame (default 8192) in which both words are zero. It is never high earlier in the run.
- R3: A word counts as zero only when every one of its SAMPLE_W bits (default 24) is 0. A single set bit in either word, including the least or most significant bit, makes the frame nonzero.
- R4: A strobed frame with a nonzero word on either channel drives the flag low on the clock edge that follows that strobe, with no hold-off.
- R5: A nonzero frame restarts the run from zero, so the flag next rises only after another RUN_FRAMES consecutive zero frames.
- R6: After the flag has risen, further zero frames keep it high for as long as they continue. The count stops at its terminal value and does not wrap, even past twice RUN_FRAMES frames.
- R7: On a cycle whose strobe is low, the flag and the run count keep their values whatever the sample inputs carry.
- R8: The run advances by exactly one per strobe, not per clock cycle, so strobes spaced several cycles apart need RUN_FRAMES strobes to raise the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | High for one cycle per stereo frame |
| left_word | input | SAMPLE_W | Left channel sample, signed |
| right_word | input | SAMPLE_W | Right channel sample, signed |
| zero_flag | output | 1 | High after a full run of all-zero stereo frames |

## Verification
The bench checks the exact frame at which the flag rises: a design that is off by one would raise it after 8191 or 8193 frames. It places single-bit nonzero words at the lowest and highest bit of each channel, which catches a zero test that ignores part of the word or only one channel. It runs the zero stream past twice the terminal count to expose a counter that wraps and drops the flag. It also spreads strobes apart and puts junk data on the idle cycles, which catches a counter that advances per clock or an idle cycle that is treated as a frame. A reset in the middle of a run shows whether the count is really cleared.

// File: rtl/zdet_pkg.sv
package zdet_pkg;

  // Classification of one clock cycle as seen by the run logic
  typedef enum logic [1:0] {
    FR_IDLE = 2'd0,  // no strobe: nothing happens
    FR_ZERO = 2'd1,  // strobed, both channels zero
    FR_LIVE = 2'd2   // strobed, some channel nonzero
  } frame_kind_e;

  function automatic frame_kind_e classify(input logic stb, input logic both_zero);
    if (!stb)      return FR_IDLE;
    if (both_zero) return FR_ZERO;
    return FR_LIVE;
  endfunction

endpackage

// File: rtl/zdet_word_zero.sv
module zdet_word_zero #(
  parameter int SAMPLE_W = 24
) (
  input  logic [SAMPLE_W-1:0] word_i,
  output logic                zero_o
);

  function automatic logic all_clear(input logic [SAMPLE_W-1:0] w);
    return (w == '0);
  endfunction

  assign zero_o = all_clear(word_i);

endmodule

// File: rtl/zdet_run_counter.sv
module zdet_run_counter
  import zdet_pkg::*;
#(
  parameter int RUN_FRAMES = 8192,
  localparam int CNT_W = $clog2(RUN_FRAMES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  frame_kind_e      kind_i,
  output logic [CNT_W-1:0] count_o,
  output logic             reach_o   // this frame completes (or keeps) a full run
);

  localparam logic [CNT_W-1:0] RUN_END = CNT_W'(RUN_FRAMES);

  // Saturating step: zero frames climb to RUN_END, live frames restart
  function automatic logic [CNT_W-1:0] count_next(input frame_kind_e k,
                                                  input logic [CNT_W-1:0] cur);
    case (k)
      FR_ZERO: return (cur == RUN_END) ? cur : cur + 1'b1;
      FR_LIVE: return '0;
      default: return cur;
    endcase
  endfunction

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_d;

  assign count_d = count_next(kind_i, count_q);
  assign reach_o = (kind_i == FR_ZERO) && (count_d == RUN_END);
  assign count_o = count_q;

  always_ff @(posedge clk) begin
    if (rst) count_q <= '0;
    else     count_q <= count_d;
  end

  // R6
  count_bounded_chk: assert property (@(posedge clk) disable iff (rst)
    count_q <= RUN_END);

  // R5
  live_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (kind_i == FR_LIVE) |=> (count_q == '0));

  // R7
  idle_hold_count_chk: assert property (@(posedge clk) disable iff (rst)
    (kind_i == FR_IDLE) |=> $stable(count_q));

  // R1
  reset_clear_count_chk: assert property (@(posedge clk)
    rst |=> (count_q == '0));

endmodule

// File: rtl/zdet_flag_reg.sv
module zdet_flag_reg
  import zdet_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  frame_kind_e kind_i,
  input  logic        reach_i,
  output logic        flag_o
);

  logic flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
    end else begin
      case (kind_i)
        FR_ZERO: flag_q <= reach_i;
        FR_LIVE: flag_q <= 1'b0;
        default: flag_q <= flag_q;
      endcase
    end
  end

  assign flag_o = flag_q;

  // R4
  live_drops_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (kind_i == FR_LIVE) |=> !flag_q);

  // R7
  idle_hold_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (kind_i == FR_IDLE) |=> $stable(flag_q));

  // R1
  reset_clear_flag_chk: assert property (@(posedge clk)
    rst |=> !flag_q);

endmodule

// File: rtl/stereo_zero_detect.sv
module stereo_zero_detect
  import zdet_pkg::*;
#(
  parameter int SAMPLE_W   = 24,
  parameter int RUN_FRAMES = 8192,
  localparam int CHANNELS  = 2,
  localparam int CNT_W     = $clog2(RUN_FRAMES + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       frame_stb,
  input  logic signed [SAMPLE_W-1:0] left_word,
  input  logic signed [SAMPLE_W-1:0] right_word,
  output logic                       zero_flag
);

  localparam logic [CNT_W-1:0] RUN_END = CNT_W'(RUN_FRAMES);

  logic [SAMPLE_W-1:0] chan_word [CHANNELS];
  logic [CHANNELS-1:0] chan_zero;

  assign chan_word[0] = left_word;
  assign chan_word[1] = right_word;

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
    zdet_word_zero #(.SAMPLE_W(SAMPLE_W)) u_zero (
      .word_i (chan_word[ch]),
      .zero_o (chan_zero[ch])
    );
  end

  // Named internal events, visible to the assertions
  logic        frame_all_zero;
  frame_kind_e frame_kind;
  logic [CNT_W-1:0] run_count;
  logic        run_full;

  assign frame_all_zero = &chan_zero;
  assign frame_kind     = classify(frame_stb, frame_all_zero);

  zdet_run_counter #(.RUN_FRAMES(RUN_FRAMES)) u_count (
    .clk     (clk),
    .rst     (rst),
    .kind_i  (frame_kind),
    .count_o (run_count),
    .reach_o (run_full)
  );

  zdet_flag_reg u_flag (
    .clk     (clk),
    .rst     (rst),
    .kind_i  (frame_kind),
    .reach_i (run_full),
    .flag_o  (zero_flag)
  );

  // R2
  rise_at_full_run_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(zero_flag) |-> (run_count == RUN_END));

  // R6
  flag_matches_count_chk: assert property (@(posedge clk) disable iff (rst)
    zero_flag == (run_count == RUN_END));

  // R6
  stays_high_chk: assert property (@(posedge clk) disable iff (rst)
    (zero_flag && frame_kind == FR_ZERO) |=> zero_flag);

endmodule

// File: tb/stereo_zero_detect_test.sv
module stereo_zero_detect_test;

  localparam int W   = 24;
  localparam int RUN = 8192;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                stb = 1'b0;
  logic signed [W-1:0] lw  = '0;
  logic signed [W-1:0] rw  = '0;
  logic                flag;

  int checks = 0;
  int errors = 0;
  int m_cnt  = 0;
  logic m_flag = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  stereo_zero_detect #(.SAMPLE_W(W), .RUN_FRAMES(RUN)) uut (
    .clk(clk), .rst(rst), .frame_stb(stb),
    .left_word(lw), .right_word(rw), .zero_flag(flag)
  );

  task automatic check(input string tag, input logic exp);
    checks++;
    if (flag !== exp) begin
      errors++;
      $display("FAIL %s: zero_flag=%b expected %b (model run=%0d) at %0t",
               tag, flag, exp, m_cnt, $time);
    end
  endtask

  // One clock cycle: drive at falling edge, update model, sample 1 ns after rise
  task automatic cycle(input logic r, input logic v,
                       input logic [W-1:0] l, input logic [W-1:0] rr,
                       input string tag);
    @(negedge clk);
    rst = r; stb = v; lw = l; rw = rr;
    @(posedge clk);
    #1;
    if (r) begin
      m_cnt = 0; m_flag = 1'b0;
    end else if (v) begin
      if (l == '0 && rr == '0) begin
        if (m_cnt < RUN) m_cnt++;
        m_flag = (m_cnt == RUN);
      end else begin
        m_cnt = 0; m_flag = 1'b0;
      end
    end
    check(tag, m_flag);
  endtask

  task automatic zeros(input int n, input string tag);
    for (int i = 0; i < n; i++) cycle(1'b0, 1'b1, '0, '0, tag);
  endtask

  // Reach a full run, then break it with a given pattern
  task automatic break_with(input logic [W-1:0] l, input logic [W-1:0] rr,
                            input string tag);
    zeros(RUN, "R2");
    check("R2 high before break", 1'b1);
    cycle(1'b0, 1'b1, l, rr, tag);
    check({tag, " flag low"}, 1'b0);
  endtask

  initial begin
    // R1: reset state
    cycle(1'b1, 1'b0, '0, '0, "R1");
    cycle(1'b1, 1'b1, '0, '0, "R1");
    check("R1 reset state", 1'b0);

    // R2: not at RUN-1, high exactly at RUN
    zeros(RUN - 1, "R2");
    check("R2 one short", 1'b0);
    zeros(1, "R2");
    check("R2 at full run", 1'b1);

    // R6: keep going past twice the run, no wrap
    zeros(RUN + 900, "R6");
    check("R6 after long run", 1'b1);

    // R3/R4: single-bit words at both ends of each channel
    cycle(1'b0, 1'b1, W'(1), '0, "R4 left lsb");
    check("R3 left lsb nonzero", 1'b0);
    break_with('0, W'(1) << (W - 1), "R3 right msb");
    break_with(W'(1) << (W - 1), '0, "R3 left msb");
    break_with('0, W'(1), "R4 right lsb");
    break_with('1, '1, "R4 both minus one");

    // R5: after a break, RUN-1 zeros is not enough
    zeros(RUN - 1, "R5");
    check("R5 restart needs full run", 1'b0);
    cycle(1'b0, 1'b1, W'(24'h000100), '0, "R5 break");
    zeros(RUN - 1, "R5");
    check("R5 still short", 1'b0);
    zeros(1, "R5");
    check("R5 full run again", 1'b1);

    // R7: idle cycles with junk data change nothing
    for (int i = 0; i < 20; i++)
      cycle(1'b0, 1'b0, W'(24'h5A5A5A), W'(24'hA5A5A5), "R7 idle");
    check("R7 flag held high", 1'b1);
    cycle(1'b0, 1'b1, '0, W'(24'h800000), "R4");
    zeros(RUN / 2, "R7");
    for (int i = 0; i < 30; i++)
      cycle(1'b0, 1'b0, W'(24'h000001), W'(24'h7FFFFF), "R7 idle mid");
    zeros(RUN / 2 - 1, "R7");
    check("R7 run not broken by idle", 1'b0);
    zeros(1, "R7");
    check("R7 run completed across idle", 1'b1);

    // R8: strobes spaced three cycles apart
    cycle(1'b0, 1'b1, W'(24'h000010), '0, "R8 break");
    for (int i = 0; i < RUN; i++) begin
      cycle(1'b0, 1'b1, '0, '0, "R8");
      if (i == RUN - 2) check("R8 one strobe short", 1'b0);
      cycle(1'b0, 1'b0, '0, '0, "R8 gap");
      cycle(1'b0, 1'b0, '0, '0, "R8 gap");
    end
    check("R8 counts strobes", 1'b1);

    // R1: reset mid-run clears the count
    cycle(1'b0, 1'b1, W'(24'h002000), '0, "R4");
    zeros(RUN - 100, "R1");
    cycle(1'b1, 1'b1, '0, '0, "R1 reset");
    check("R1 reset clears flag", 1'b0);
    zeros(200, "R1");
    check("R1 count cleared by reset", 1'b0);
    zeros(RUN - 200, "R1");
    check("R1 full run after reset", 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 190000);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule